// File: doc/BRIEF.md
# Mode-Programmable Accumulator Slice

This block is a narrow register with a full adder in front of it. A 3-bit program code selects what the register does on each rising clock edge. Four arithmetic codes pass the adder sum to the register: add, subtract, count up and count down. Four direct codes bypass the adder: clear, load, shift right and shift left. Because the count modes use the same adder with a fixed addend, the slice needs no separate counter logic.

Slices are chained into wider words. The carry output of one slice drives the carry input of the next more significant slice. Each end bit of a slice can be fed from its neighbour through the two serial shift pins. When a chained word counts, the lowest slice uses a count code. The upper slices use the add code with a data input of all zeros (for counting up) or all ones (for counting down), so the carry can ripple upward.

Top module: `prog_acc_slice`

## Requirements
- R1: When `rst` is high, `acc` becomes zero at once, without waiting for a clock edge, and stays zero while `rst` stays high.
- R2: Code `prog`=3'b100 (bit 2 is r, bit 1 is q, bit 0 is p) makes `acc` zero on the next clock edge, whatever the values of `din`, `cin` and the shift pins.
- R3: Code 3'b111 writes `din` into `acc` on the next edge. No earlier clear is needed.
- R4: Code 3'b011 stores `acc + din + cin`, taken modulo 2^W.
- R5: Code 3'b000 stores `acc + ~din + cin`. With `cin`=1 the result is `acc - din`.
- R6: Code 3'b001 stores `acc + 1 + cin`. With `cin` held at 0 this counts up by one and wraps from all ones to zero.
- R7: Code 3'b010 stores `acc + (all ones) + cin`. With `cin` held at 0 this counts down by one and wraps from zero to all ones.
- R8: Code 3'b101 shifts toward the least significant bit. Bit i takes bit i+1, and the most significant bit takes `shr_in`.
- R9: Code 3'b110 shifts toward the most significant bit. Bit i takes bit i-1, and bit 0 takes `shl_in`.
- R10: `cout` is the combinational carry out of the adder's top bit while `prog[2]`=0. It is 0 while `prog[2]`=1.
- R11: Two slices behave as one 2W-bit accumulator when wired as follows. The lower slice's `cout` drives the upper slice's `cin`. The upper slice's bit 0 drives the lower slice's `shr_in`. The lower slice's top bit drives the upper slice's `shl_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| prog | input | 3 | Program code {r,q,p} |
| din | input | W | Data input: addend, subtrahend or load value |
| cin | input | 1 | Carry input into the adder's bit 0 |
| shr_in | input | 1 | Serial input to the top bit during a right shift |
| shl_in | input | 1 | Serial input to bit 0 during a left shift |
| acc | output | W | Stored state |
| cout | output | 1 | Carry out of the adder's top bit, gated by r |

## Verification
The bench builds two slices with the default W=4 and chains them into an 8-bit word through the carry and both shift links. This brings several cases within reach: carries that cross the nibble boundary, wrap-around at 0xFF and 0x00 in both count directions, subtraction that borrows through both slices, and bits that cross between slices during shifts. A reference model of the 8-bit word, run alongside the design, predicts each stored value and the top carry. An asynchronous reset in the middle of a cycle is checked between clock edges.

// File: rtl/prog_acc_slice.sv
module prog_acc_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   prog,
  input  logic [W-1:0] din,
  input  logic         cin,
  input  logic         shr_in,
  input  logic         shl_in,
  output logic [W-1:0] acc,
  output logic         cout
);

  logic         bypass;
  logic [W-1:0] addend;
  logic [W:0]   sum;
  logic [W-1:0] direct;
  logic [W-1:0] nxt;

  assign bypass = prog[2];

  always_comb begin
    unique case (prog[1:0])
      2'b00:   addend = ~din;
      2'b01:   addend = W'(1);
      2'b10:   addend = '1;
      default: addend = din;
    endcase
  end

  assign sum  = {1'b0, acc} + {1'b0, addend} + (W+1)'(cin);
  assign cout = ~bypass & sum[W];

  always_comb begin
    unique case (prog[1:0])
      2'b00:   direct = '0;
      2'b01:   direct = {shr_in, acc[W-1:1]};
      2'b10:   direct = {acc[W-2:0], shl_in};
      default: direct = din;
    endcase
  end

  assign nxt = bypass ? direct : sum[W-1:0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) acc <= '0;
    else     acc <= nxt;
  end

endmodule

// File: rtl/prog_acc_slice_chk.sv
module prog_acc_slice_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   prog,
  input logic [W-1:0] din,
  input logic         cin,
  input logic         shr_in,
  input logic         shl_in,
  input logic [W-1:0] acc,
  input logic         cout
);

  assert_reset_zero_R1: assert property (@(posedge clk) rst |-> acc == '0);

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    prog == 3'b100 |=> acc == '0);

  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    prog == 3'b111 |=> acc == $past(din));

  assert_count_up_R6: assert property (@(posedge clk) disable iff (rst)
    (prog == 3'b001 && !cin) |=> acc == W'($past(acc) + W'(1)));

  assert_shift_right_R8: assert property (@(posedge clk) disable iff (rst)
    prog == 3'b101 |=> acc == {$past(shr_in), $past(acc[W-1:1])});

  assert_shift_left_R9: assert property (@(posedge clk) disable iff (rst)
    prog == 3'b110 |=> acc == {$past(acc[W-2:0]), $past(shl_in)});

  assert_no_carry_bypass_R10: assert property (@(posedge clk) disable iff (rst)
    prog[2] |-> !cout);

endmodule

bind prog_acc_slice prog_acc_slice_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .prog(prog), .din(din), .cin(cin),
  .shr_in(shr_in), .shl_in(shl_in), .acc(acc), .cout(cout)
);

// File: tb/tb_prog_acc_slice.sv
`timescale 1ns/1ps
module tb_prog_acc_slice;
  localparam int W = 4;

  typedef enum {O_CLR, O_LD, O_ADD, O_SUB, O_INC, O_DEC, O_SHR, O_SHL} op_e;

  logic       clk = 0;
  logic       rst = 1;
  logic [2:0] lo_prog = 3'b100, hi_prog = 3'b100;
  logic [7:0] din8 = '0;
  logic [W-1:0] hi_din;
  logic       lo_cin = 0, ext_shr = 0, ext_shl = 0;
  logic [W-1:0] lo_acc, hi_acc;
  logic       lo_cout, hi_cout;
  logic       dec_mode = 0, inc_mode = 0;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] model = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  assign hi_din = inc_mode ? '0 : (dec_mode ? '1 : din8[7:4]);

  prog_acc_slice #(.W(W)) dut (
    .clk(clk), .rst(rst), .prog(lo_prog), .din(din8[3:0]), .cin(lo_cin),
    .shr_in(hi_acc[0]), .shl_in(ext_shl), .acc(lo_acc), .cout(lo_cout));

  prog_acc_slice #(.W(W)) dut_hi (
    .clk(clk), .rst(rst), .prog(hi_prog), .din(hi_din), .cin(lo_cout),
    .shr_in(ext_shr), .shl_in(lo_acc[W-1]), .acc(hi_acc), .cout(hi_cout));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, want);
    end
  endtask

  function automatic string tag_of(op_e op);
    case (op)
      O_CLR: return "R2";
      O_LD:  return "R3";
      O_ADD: return "R4 R11";
      O_SUB: return "R5 R11";
      O_INC: return "R6 R11";
      O_DEC: return "R7 R11";
      O_SHR: return "R8 R11";
      default: return "R9 R11";
    endcase
  endfunction

  task automatic drive(input op_e op, input logic [7:0] d, input logic c,
                       input logic sr, input logic sl);
    logic [8:0] s;
    logic [7:0] nx;
    logic       ec;
    @(negedge clk);
    din8 = d; lo_cin = c; ext_shr = sr; ext_shl = sl;
    inc_mode = (op == O_INC); dec_mode = (op == O_DEC);
    case (op)
      O_CLR: begin lo_prog = 3'b100; hi_prog = 3'b100; end
      O_LD:  begin lo_prog = 3'b111; hi_prog = 3'b111; end
      O_ADD: begin lo_prog = 3'b011; hi_prog = 3'b011; end
      O_SUB: begin lo_prog = 3'b000; hi_prog = 3'b000; end
      O_INC: begin lo_prog = 3'b001; hi_prog = 3'b011; end
      O_DEC: begin lo_prog = 3'b010; hi_prog = 3'b011; end
      O_SHR: begin lo_prog = 3'b101; hi_prog = 3'b101; end
      default: begin lo_prog = 3'b110; hi_prog = 3'b110; end
    endcase
    s = 9'd0; ec = 1'b0;
    case (op)
      O_CLR: nx = 8'h00;
      O_LD:  nx = d;
      O_ADD: begin s = {1'b0, model} + {1'b0, d} + 9'(c); nx = s[7:0]; ec = s[8]; end
      O_SUB: begin s = {1'b0, model} + {1'b0, ~d} + 9'(c); nx = s[7:0]; ec = s[8]; end
      O_INC: begin s = {1'b0, model} + 9'd1; nx = s[7:0]; ec = s[8]; end
      O_DEC: begin s = {1'b0, model} + 9'h0FF; nx = s[7:0]; ec = s[8]; end
      O_SHR: nx = {sr, model[7:1]};
      default: nx = {model[6:0], sl};
    endcase
    #1;
    chk("R10 R11 carry", {7'd0, hi_cout}, {7'd0, ec});
    exp_q.push_back(nx);
    tag_q.push_back(tag_of(op));
    model = nx;
  endtask

  always begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      logic [7:0] v;
      string t;
      v = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {hi_acc, lo_acc}, v);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset state", {hi_acc, lo_acc}, 8'h00);
    @(negedge clk);
    rst = 0;
    model = 8'h00;

    drive(O_LD, 8'hA5, 1'b1, 1'b1, 1'b1);
    drive(O_CLR, 8'h3C, 1'b1, 1'b1, 1'b1);
    drive(O_LD, 8'hF0, 1'b0, 1'b0, 1'b0);
    drive(O_LD, 8'h5A, 1'b0, 1'b0, 1'b0);
    drive(O_ADD, 8'h20, 1'b0, 1'b0, 1'b0);
    drive(O_ADD, 8'hC0, 1'b0, 1'b0, 1'b0);
    drive(O_ADD, 8'h0F, 1'b1, 1'b0, 1'b0);
    drive(O_ADD, 8'h08, 1'b0, 1'b0, 1'b0);
    drive(O_SUB, 8'h30, 1'b1, 1'b0, 1'b0);
    drive(O_SUB, 8'h01, 1'b1, 1'b0, 1'b0);
    drive(O_SUB, 8'hFF, 1'b1, 1'b0, 1'b0);
    drive(O_SUB, 8'h05, 1'b0, 1'b0, 1'b0);
    drive(O_LD, 8'h0E, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) drive(O_INC, 8'h77, 1'b0, 1'b0, 1'b0);
    drive(O_LD, 8'hFE, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) drive(O_INC, 8'h00, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) drive(O_DEC, 8'h00, 1'b0, 1'b0, 1'b0);
    drive(O_LD, 8'h10, 1'b0, 1'b0, 1'b0);
    drive(O_DEC, 8'h00, 1'b0, 1'b0, 1'b0);
    drive(O_LD, 8'h96, 1'b0, 1'b0, 1'b0);
    drive(O_SHR, 8'hFF, 1'b1, 1'b1, 1'b0);
    drive(O_SHR, 8'h00, 1'b0, 1'b0, 1'b1);
    drive(O_SHR, 8'h00, 1'b0, 1'b0, 1'b1);
    drive(O_SHL, 8'hFF, 1'b1, 1'b1, 1'b0);
    drive(O_SHL, 8'h00, 1'b0, 1'b0, 1'b1);
    drive(O_SHL, 8'h00, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) drive(O_ADD, 8'h3B, 1'b0, 1'b0, 1'b0);

    drive(O_LD, 8'hC3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    lo_prog = 3'b011; hi_prog = 3'b011; din8 = 8'h00; lo_cin = 0;
    @(posedge clk);
    #3;
    rst = 1;
    #1;
    chk("R1 async clear", {hi_acc, lo_acc}, 8'h00);
    @(posedge clk);
    #1;
    chk("R1 held in reset", {hi_acc, lo_acc}, 8'h00);
    @(negedge clk);
    rst = 0;
    model = 8'h00;
    drive(O_INC, 8'h00, 1'b0, 1'b0, 1'b0);
    drive(O_INC, 8'h00, 1'b0, 1'b0, 1'b0);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule